// File: doc/BRIEF.md
# Three-Level DMA Address Translation Walker

This block maps a device DMA address to a host page address by walking three tables held in memory: a region table, a segment table and a page table. A request carries the DMA address, the table origin, an inclusive address window (base and limit), the state of the requesting function and a translation-enable bit. The block first decides whether the request may be translated at all. If it may, it reads the three table entries one after another through a 64-bit read port and returns a host page address, an address mask and a permission.

Requests are accepted on a valid/ready handshake. A request is taken when `req_valid` and `req_ready` are both high at a clock edge, and `req_ready` is high only while the walker is idle. Memory reads leave on a valid/ready handshake. Once a read is issued, `rd_req_valid` and `rd_addr` stay fixed until `rd_req_ready` takes them. Read data comes back on `rd_data_valid`, which has no ready, and the block has at most one read outstanding. The result is offered on `resp_valid` and holds every output field fixed until `resp_ready` takes it. The requester can stall the result for any number of cycles.

Each intermediate entry carries a two-bit type code. The walker uses the entry's address only when that code matches the level being read. On a mismatch the walk ends quietly with no access granted, and no fault is raised.

Top module: `io_xlate_walker`

## Requirements
- R1: A request is translated only when `req_fstate` is 3 (enabled) or 4 (blocked) and `req_xlate_en` is 1. Otherwise the result is permission 2'b00, address 0 and mask all ones, and no memory read is issued.
- R2: A DMA address below `req_base` or above `req_limit` returns permission 2'b00, address 0 and mask all ones, with no memory read. Both bounds are inclusive.
- R3: The first read is at the origin with bits [3:2] cleared, plus 8 times the region index. The region index is DMA address bits [41:31].
- R4: The second read is at the region entry with bits [11:0] cleared, plus 8 times DMA bits [30:20]. The third read is at the segment entry with bits [11:0] cleared, plus 8 times DMA bits [19:12].
- R5: Entry bits [3:2] must equal 3 in a region entry and 2 in a segment entry. If they do not, the walk ends with no further read, and the result is permission 2'b00, address 0 and mask all ones.
- R6: When the walk completes, `resp_paddr` is the page entry with bits [11:0] cleared and `resp_mask` is 0xfff.
- R7: Permission is 2'b11 (bit 0 read, bit 1 write) when page-entry bit 10 is clear. When bit 10 is set, the permission is 2'b00 and the address and mask are still as in R6. A page entry that is all zeros gives permission 2'b00, address 0 and mask all ones.
- R8: At most one read is outstanding: no new read request appears until the previous read's data has returned. `req_ready` is high only while no request is in progress.
- R9: While `rd_req_valid` is high and `rd_req_ready` is low, `rd_addr` holds. While `resp_valid` is high and `resp_ready` is low, every response field holds.
- R10: After reset, `req_ready` is 1 and both `rd_req_valid` and `resp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_dma_addr | input | 64 | Device DMA address to translate |
| req_origin | input | 64 | Region table origin; bits [3:2] are flags |
| req_base | input | 64 | Lowest allowed DMA address |
| req_limit | input | 64 | Highest allowed DMA address |
| req_fstate | input | 3 | Function state: 0 reserved, 1 standby, 2 disabled, 3 enabled, 4 blocked |
| req_xlate_en | input | 1 | Translation enabled for the function |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 64 | Byte address of the 64-bit entry |
| rd_data_valid | input | 1 | Read data present |
| rd_data | input | 64 | Entry read from memory |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_paddr | output | 64 | Translated page address |
| resp_mask | output | 64 | Address mask of the result |
| resp_perm | output | 2 | Bit 0 read, bit 1 write |

## Verification
The hardest case to reach from the ports is a type mismatch found only at the second level. The region entry has to be correct so the walker reaches the segment read, and the segment entry has to carry the wrong code. The bench reaches this by building the tables in its own memory for each request, giving the region entry type 3 and the segment entry type 1. It then checks that exactly two reads occur. Random stalls on both `rd_req_ready` and `resp_ready` drive the hold rules during walks that end early and walks that run to completion.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    FS_RESERVED = 3'd0,
    FS_STANDBY  = 3'd1,
    FS_DISABLED = 3'd2,
    FS_ENABLED  = 3'd3,
    FS_BLOCKED  = 3'd4
  } fstate_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_RGN,
    W_SEG,
    W_PAGE,
    W_DONE
  } walk_e;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;
  localparam logic [1:0] TYPE_RGN  = 2'd3;
  localparam logic [1:0] TYPE_SEG  = 2'd2;
endpackage

// File: rtl/xw_slot_addr.sv
module xw_slot_addr #(
  parameter int AW  = 64,
  parameter int LSB = 31,
  parameter int W   = 11
) (
  input  logic [AW-1:0] tbl,
  input  logic [AW-1:0] dma,
  output logic [AW-1:0] slot
);
  localparam int SW = W + 3;
  logic [SW-1:0] off;
  always_comb begin
    off  = {dma[LSB +: W], 3'b000};
    slot = tbl + AW'(off);
  end
endmodule

// File: rtl/xw_entry_decode.sv
module xw_entry_decode #(
  parameter int         AW         = 64,
  parameter int         TYPE_LSB   = 2,
  parameter int         PAGE_SHIFT = 12,
  parameter logic [1:0] EXP_TYPE   = 2'd3
) (
  input  logic [AW-1:0] entry,
  output logic [AW-1:0] next_tbl,
  output logic          match
);
  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);
  always_comb begin
    match    = (entry[TYPE_LSB +: 2] == EXP_TYPE);
    next_tbl = entry & ~LOW_MASK;
  end
endmodule

// File: rtl/io_xlate_walker.sv
module io_xlate_walker
  import xw_pkg::*;
#(
  parameter int AW          = 64,
  parameter int RTX_LSB     = 31,
  parameter int RTX_W       = 11,
  parameter int SX_LSB      = 20,
  parameter int SX_W        = 11,
  parameter int PX_LSB      = 12,
  parameter int PX_W        = 8,
  parameter int PAGE_SHIFT  = 12,
  parameter int TYPE_LSB    = 2,
  parameter int INV_BIT     = 10,
  parameter int ORG_FLAG_LSB = 2,
  parameter int ORG_FLAG_W  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_dma_addr,
  input  logic [AW-1:0] req_origin,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_limit,
  input  logic [2:0]    req_fstate,
  input  logic          req_xlate_en,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_data_valid,
  input  logic [AW-1:0] rd_data,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [AW-1:0] resp_paddr,
  output logic [AW-1:0] resp_mask,
  output logic [1:0]    resp_perm
);
  localparam logic [AW-1:0] PAGE_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);
  localparam logic [AW-1:0] ORG_FLAGS =
      ((AW'(1) << ORG_FLAG_W) - AW'(1)) << ORG_FLAG_LSB;

  walk_e         st_q;
  logic          pend_q;
  logic [AW-1:0] dma_q, base_q, limit_q, tbl_q;
  logic [AW-1:0] rgn_slot, seg_slot, page_slot;
  logic [AW-1:0] rgn_next, seg_next;
  logic          rgn_ok, seg_ok;
  logic          fs_ok, in_win, req_fire, data_in;

  xw_slot_addr #(.AW(AW), .LSB(RTX_LSB), .W(RTX_W)) u_rgn_slot (
    .tbl(tbl_q), .dma(dma_q), .slot(rgn_slot));
  xw_slot_addr #(.AW(AW), .LSB(SX_LSB), .W(SX_W)) u_seg_slot (
    .tbl(tbl_q), .dma(dma_q), .slot(seg_slot));
  xw_slot_addr #(.AW(AW), .LSB(PX_LSB), .W(PX_W)) u_page_slot (
    .tbl(tbl_q), .dma(dma_q), .slot(page_slot));

  xw_entry_decode #(.AW(AW), .TYPE_LSB(TYPE_LSB), .PAGE_SHIFT(PAGE_SHIFT),
                    .EXP_TYPE(TYPE_RGN)) u_rgn_dec (
    .entry(rd_data), .next_tbl(rgn_next), .match(rgn_ok));
  xw_entry_decode #(.AW(AW), .TYPE_LSB(TYPE_LSB), .PAGE_SHIFT(PAGE_SHIFT),
                    .EXP_TYPE(TYPE_SEG)) u_seg_dec (
    .entry(rd_data), .next_tbl(seg_next), .match(seg_ok));

  always_comb begin
    req_ready    = (st_q == W_IDLE);
    req_fire     = req_valid && req_ready;
    fs_ok        = ((req_fstate == FS_ENABLED) || (req_fstate == FS_BLOCKED))
                   && req_xlate_en;
    in_win       = (req_dma_addr >= req_base) && (req_dma_addr <= req_limit);
    rd_req_valid = !pend_q &&
                   ((st_q == W_RGN) || (st_q == W_SEG) || (st_q == W_PAGE));
    data_in      = pend_q && rd_data_valid;
    resp_valid   = (st_q == W_DONE);
    unique case (st_q)
      W_SEG:   rd_addr = seg_slot;
      W_PAGE:  rd_addr = page_slot;
      default: rd_addr = rgn_slot;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= W_IDLE;
      pend_q     <= 1'b0;
      dma_q      <= '0;
      base_q     <= '0;
      limit_q    <= '0;
      tbl_q      <= '0;
      resp_paddr <= '0;
      resp_mask  <= '1;
      resp_perm  <= PERM_NONE;
    end else begin
      if (rd_req_valid && rd_req_ready) pend_q <= 1'b1;
      if (data_in) pend_q <= 1'b0;
      unique case (st_q)
        W_IDLE: if (req_fire) begin
          dma_q      <= req_dma_addr;
          base_q     <= req_base;
          limit_q    <= req_limit;
          tbl_q      <= req_origin & ~ORG_FLAGS;
          resp_paddr <= '0;
          resp_mask  <= '1;
          resp_perm  <= PERM_NONE;
          st_q       <= (fs_ok && in_win) ? W_RGN : W_DONE;
        end
        W_RGN: if (data_in) begin
          tbl_q <= rgn_next;
          st_q  <= rgn_ok ? W_SEG : W_DONE;
        end
        W_SEG: if (data_in) begin
          tbl_q <= seg_next;
          st_q  <= seg_ok ? W_PAGE : W_DONE;
        end
        W_PAGE: if (data_in) begin
          st_q <= W_DONE;
          if (rd_data != '0) begin
            resp_paddr <= rd_data & ~PAGE_MASK;
            resp_mask  <= PAGE_MASK;
            resp_perm  <= rd_data[INV_BIT] ? PERM_NONE : PERM_RW;
          end
        end
        W_DONE: if (resp_ready) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr) && $stable(resp_mask) && $stable(resp_perm)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr)); // R9
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid); // R8
  AST_GRANT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_perm != PERM_NONE) |-> (dma_q >= base_q) && (dma_q <= limit_q)); // R2
  AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_perm != PERM_NONE) |-> (resp_mask == PAGE_MASK) && ((resp_paddr & PAGE_MASK) == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_req_valid && !resp_valid); // R8
endmodule

// File: tb/tb_io_xlate_walker.sv
`timescale 1ns/1ps
module tb_io_xlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_dma_addr = '0, req_origin = '0, req_base = '0, req_limit = '0;
  logic [2:0]  req_fstate = '0;
  logic        req_xlate_en = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [63:0] rd_addr;
  logic        rd_data_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [63:0] resp_paddr, resp_mask;
  logic [1:0]  resp_perm;

  int errors = 0;
  int checks = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_q[$];
  logic [63:0] exp_pa, exp_mk;
  logic [1:0]  exp_pm;
  int  rd_idx = 0;
  bit  busy = 0, got = 0, stall = 0;
  bit  hold_r = 0, hold_m = 0;
  logic [63:0] h_pa, h_mk, h_ra;
  logic [1:0]  h_pm;

  always #2.5 clk = ~clk;

  io_xlate_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dma_addr(req_dma_addr), .req_origin(req_origin), .req_base(req_base),
    .req_limit(req_limit), .req_fstate(req_fstate), .req_xlate_en(req_xlate_en),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_paddr(resp_paddr), .resp_mask(resp_mask),
    .resp_perm(resp_perm));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rdm(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // memory responder: one-cycle latency, optional ready stalls
  always @(posedge clk) begin
    rd_data_valid <= rd_req_valid && rd_req_ready;
    rd_data       <= rdm(rd_addr);
    rd_req_ready  <= stall ? (($urandom % 3) != 0) : 1'b1;
  end

  // behavioural reference walk
  task automatic model(input logic [63:0] dma, org, base, lim, input logic [2:0] fs, input bit en);
    logic [63:0] a, e;
    exp_pa = 64'h0; exp_mk = '1; exp_pm = 2'b00; exp_q.delete();
    if (!((fs == 3'd3 || fs == 3'd4) && en)) return;
    if (dma < base || dma > lim) return;
    a = (org & ~64'hC) + 64'({dma[41:31], 3'b000});
    exp_q.push_back(a); e = rdm(a);
    if (e[3:2] != 2'd3) return;
    a = (e & ~64'hFFF) + 64'({dma[30:20], 3'b000});
    exp_q.push_back(a); e = rdm(a);
    if (e[3:2] != 2'd2) return;
    a = (e & ~64'hFFF) + 64'({dma[19:12], 3'b000});
    exp_q.push_back(a); e = rdm(a);
    if (e == 64'h0) return;
    exp_pa = e & ~64'hFFF; exp_mk = 64'hFFF; exp_pm = e[10] ? 2'b00 : 2'b11;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    if (hold_m) chk(resp_valid && resp_paddr == h_pa && resp_mask == h_mk && resp_perm == h_pm,
                    "R9 response hold", resp_paddr, h_pa);
    if (hold_r) chk(rd_req_valid && rd_addr == h_ra, "R9 read hold", rd_addr, h_ra);
    if (!busy && (resp_valid || rd_req_valid))
      chk(0, "R8 activity without request", {62'h0, resp_valid, rd_req_valid}, 64'h0);
    hold_r = rd_req_valid && !rd_req_ready; h_ra = rd_addr;
    if (rd_req_valid && rd_req_ready) begin
      if (exp_q.size() == 0) chk(0, "R1 R2 R5 unexpected read", rd_addr, 64'h0);
      else begin
        logic [63:0] ea;
        ea = exp_q.pop_front();
        if (rd_idx == 0) chk(rd_addr == ea, "R3 region read address", rd_addr, ea);
        else chk(rd_addr == ea, "R4 lower read address", rd_addr, ea);
      end
      rd_idx++;
    end
    resp_ready = stall ? (($urandom % 2) != 0) : 1'b1;
    hold_m = resp_valid && !resp_ready;
    h_pa = resp_paddr; h_mk = resp_mask; h_pm = resp_perm;
    if (busy && resp_valid && resp_ready) begin
      chk(exp_q.size() == 0, "R5 R8 missing reads", 64'(exp_q.size()), 64'h0);
      chk(resp_paddr == exp_pa, "R6 paddr", resp_paddr, exp_pa);
      chk(resp_mask == exp_mk, "R6 mask", resp_mask, exp_mk);
      chk(resp_perm == exp_pm, "R7 perm", 64'(resp_perm), 64'(exp_pm));
      got = 1; busy = 0;
    end
  end

  task automatic do_req(input logic [63:0] dma, org, base, lim, input logic [2:0] fs, input bit en);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model(dma, org, base, lim, fs, en);
    rd_idx = 0; busy = 1; got = 0;
    req_dma_addr = dma; req_origin = org; req_base = base; req_limit = lim;
    req_fstate = fs; req_xlate_en = en; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got) @(negedge clk);
  endtask

  task automatic build(input logic [63:0] dma, org, input logic [1:0] rt, st, input logic [63:0] pte);
    logic [63:0] s, p;
    mem.delete();
    s = 64'h0020_0000; p = 64'h0040_0000;
    mem[(org & ~64'hC) + 64'({dma[41:31], 3'b000})] = s | 64'({rt, 2'b00});
    mem[s + 64'({dma[30:20], 3'b000})] = p | 64'({st, 2'b00});
    mem[p + 64'({dma[19:12], 3'b000})] = pte;
  endtask

  localparam logic [63:0] ORG = 64'h0001_0000;
  localparam logic [63:0] DMA = 64'h0000_0123_4567_8ABC;
  localparam logic [63:0] LO  = 64'h0000_0100_0000_0000;
  localparam logic [63:0] HI  = 64'h0000_0200_0000_0000;

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 64'h0, 64'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rd_req_valid && !resp_valid, "R10 reset state",
        {61'h0, req_ready, rd_req_valid, resp_valid}, 64'h4);
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      stall = (pass == 1);
      // R6 R7 full walk, enabled and blocked states
      build(DMA, ORG, 2'd3, 2'd2, 64'h0000_00AB_CDEF_5000);
      do_req(DMA, ORG, LO, HI, 3'd3, 1'b1);
      do_req(DMA, ORG, LO, HI, 3'd4, 1'b1);
      // R1 other states and translation disabled
      do_req(DMA, ORG, LO, HI, 3'd2, 1'b1);
      do_req(DMA, ORG, LO, HI, 3'd1, 1'b1);
      do_req(DMA, ORG, LO, HI, 3'd3, 1'b0);
      // R2 window edges
      do_req(DMA, ORG, DMA + 1, HI, 3'd3, 1'b1);
      do_req(DMA, ORG, LO, DMA - 1, 3'd3, 1'b1);
      do_req(DMA, ORG, DMA, DMA, 3'd3, 1'b1);
      // R3 origin flag bits ignored
      build(DMA, ORG | 64'hC, 2'd3, 2'd2, 64'h0000_0000_7777_7000);
      do_req(DMA, ORG | 64'hC, LO, HI, 3'd3, 1'b1);
      // R5 region and segment type mismatch
      build(DMA, ORG, 2'd2, 2'd2, 64'h0000_0000_1111_1000);
      do_req(DMA, ORG, LO, HI, 3'd3, 1'b1);
      build(DMA, ORG, 2'd3, 2'd1, 64'h0000_0000_1111_1000);
      do_req(DMA, ORG, LO, HI, 3'd4, 1'b1);
      // R7 invalid flag and empty page entry
      build(DMA, ORG, 2'd3, 2'd2, 64'h0000_0000_2222_2400);
      do_req(DMA, ORG, LO, HI, 3'd3, 1'b1);
      build(DMA, ORG, 2'd3, 2'd2, 64'h0);
      do_req(DMA, ORG, LO, HI, 3'd3, 1'b1);
      // R4 different indices
      for (int k = 0; k < 4; k++) begin
        logic [63:0] d;
        d = LO + 64'(k) * 64'h0000_0000_8010_3000 + 64'h0000_0000_0000_0123;
        build(d, ORG, 2'd3, 2'd2, 64'h0000_0000_0100_0000 + 64'(k) * 64'h1000 + 64'h0FF);
        do_req(d, ORG, LO, HI, 3'd3, 1'b1);
      end
    end
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule